// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between on-chip logic and an external asynchronous static RAM. The RAM has a 13-bit address and an 8-bit data bus that is shared by reads and writes. Internal logic issues one request at a time: a write with an address and a data byte, or a read with an address. The block then steps the RAM pins through a fixed multi-cycle sequence. It reports completion of a read by presenting the byte together with a one-cycle valid pulse.

Every pin toward the RAM comes straight from a flip-flop, so no strobe can glitch. The controller drives the shared data bus only inside a bounded write window. During that window the output enable stays inactive, and the address is held from before the write strobe falls until after it rises. A read spends a parameterized number of cycles with output enable active before the bus is sampled. It then spends one extra turnaround cycle before the controller accepts new work. While a sequence runs, a busy output is high and the request input is ignored.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and after a reset that lands in the middle of a sequence, the RAM pins are in the idle state. That means `ram_sel_n`=1, `ram_sel`=0, `ram_wr_n`=1 and `ram_rd_n`=1, with `busy`=0 and `rd_valid`=0.
- R2: A request is accepted on a clock edge where `req_valid`=1 and `busy`=0. `busy` is 1 from the next cycle until the sequence ends. A request presented while `busy`=1 is ignored, and `ram_addr` does not change during that time.
- R3: In a write (`req_write`=1), the cycle after acceptance selects the chip and puts the address and data on the pins with `ram_wr_n`=1 for SETUP_CYC cycles (default 1). Then `ram_wr_n`=0 for PULSE_CYC cycles (default 2). Then one cycle follows with `ram_wr_n`=1 while the data is still driven. After that the chip is deselected and `busy` falls.
- R4: `ram_addr` holds the requested address for the whole write, including the cycle in which `ram_wr_n` rises.
- R5: In a read (`req_write`=0), the cycle after acceptance selects the chip with `ram_rd_n`=1 for SETUP_CYC cycles. Then `ram_rd_n`=0 for RD_WAIT cycles (default 2). `ram_rd_n` is low only while the chip is selected and `ram_wr_n`=1.
- R6: The bus value in the last cycle with `ram_rd_n`=0 is registered to `rd_data`. `rd_valid` pulses for exactly one cycle, namely the cycle after `ram_rd_n` rises. `rd_data` then holds until the next read completes.
- R7: Each read ends with one turnaround cycle in which `ram_rd_n`=1, the controller does not drive the bus and `busy`=1. Only after that does the block return to idle.
- R8: The controller drives the data bus only while `ram_rd_n`=1. `ram_wr_n` is low only while the chip is selected and the bus is driven.
- R9: A read of an address returns the byte most recently written to it through the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Sequence in progress; requests ignored |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| rd_data | output | 8 | Last byte read |
| ram_sel_n | output | 1 | Active-low chip enable |
| ram_sel | output | 1 | Active-high chip enable |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_addr | output | 13 | RAM address |
| ram_dq | inout | 8 | Shared tristate data bus |

## Verification
Several pin rules are checked on every cycle by properties:
- the bus is never driven while output enable is active;
- the write strobe falls only with the chip selected and the data driven, and the data is still driven when the strobe rises;
- the address stays frozen while busy and at the strobe's rising edge;
- read-valid is a single pulse that follows an output-enable cycle;
- the turnaround cycle leaves the bus undriven.

The exact cycle counts of each phase, the rejection of requests while busy and the data path through an external memory model can only be shown by the bench's scenarios. Those scenarios are a write/read vector table, an overlapped request, and a reset in the middle of a read.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSET   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RSET   = 3'd4,
    ST_RWAIT  = 3'd5,
    ST_RTURN  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
  import asram_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RD_WAIT   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       accept,
  output seq_state_t nxt_state,
  output logic       capture
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > RD_WAIT) ? SETUP_CYC : RD_WAIT) :
                        ((PULSE_CYC > RD_WAIT) ? PULSE_CYC : RD_WAIT);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] L_SET   = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_WAIT  = CW'(RD_WAIT - 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last    = (cnt_q == '0);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_RWAIT) && last;

  always_comb begin
    nxt_state = state_q;
    cnt_d     = cnt_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        nxt_state = req_write ? ST_WSET : ST_RSET;
        cnt_d     = L_SET;
      end
      ST_WSET: if (last) begin
        nxt_state = ST_WPULSE;
        cnt_d     = L_PULSE;
      end else cnt_d = cnt_q - 1'b1;
      ST_WPULSE: if (last) nxt_state = ST_WHOLD;
                 else cnt_d = cnt_q - 1'b1;
      ST_WHOLD: nxt_state = ST_IDLE;
      ST_RSET: if (last) begin
        nxt_state = ST_RWAIT;
        cnt_d     = L_WAIT;
      end else cnt_d = cnt_q - 1'b1;
      ST_RWAIT: if (last) nxt_state = ST_RTURN;
                else cnt_d = cnt_q - 1'b1;
      ST_RTURN: nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= cnt_d;
    end
  end

  // R2: once a sequence has started, the controller leaves idle only through its own path
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> $past(req_valid));
  // R7: a read always passes through the turnaround state before idle
  p_turn_after_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RWAIT && last) |=> state_q == ST_RTURN);
endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv
  import asram_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  seq_state_t    nxt_state,
  input  logic          capture,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_wr_n,
  output logic          ram_rd_n,
  output logic [AW-1:0] ram_addr,
  inout  wire  [DW-1:0] ram_dq
);
  logic          drive_q;
  logic [DW-1:0] wdata_q;
  logic          nxt_active, nxt_drive;

  assign nxt_active = (nxt_state != ST_IDLE);
  assign nxt_drive  = (nxt_state == ST_WSET) || (nxt_state == ST_WPULSE) ||
                      (nxt_state == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ram_sel_n <= 1'b1;
      ram_sel   <= 1'b0;
      ram_wr_n  <= 1'b1;
      ram_rd_n  <= 1'b1;
      drive_q   <= 1'b0;
      rd_valid  <= 1'b0;
      ram_addr  <= '0;
      wdata_q   <= '0;
      rd_data   <= '0;
    end else begin
      busy      <= nxt_active;
      ram_sel_n <= ~nxt_active;
      ram_sel   <= nxt_active;
      ram_wr_n  <= ~(nxt_state == ST_WPULSE);
      ram_rd_n  <= ~(nxt_state == ST_RWAIT);
      drive_q   <= nxt_drive;
      rd_valid  <= capture;
      if (accept) begin
        ram_addr <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (capture) rd_data <= ram_dq;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_bus
    assign ram_dq[i] = drive_q ? wdata_q[i] : 1'bz;
  end

  // R8: never drive the bus while the RAM may drive it
  p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> ram_rd_n);
  // R8: write strobe only with chip selected and data on the bus
  p_we_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !ram_wr_n |-> (drive_q && !ram_sel_n && ram_sel));
  // R3: data still driven when the write strobe rises
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_wr_n) |-> drive_q);
  // R4: address unchanged at the strobe's rising edge
  p_addr_we_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_wr_n) |-> $stable(ram_addr));
  // R2: address frozen while a sequence runs
  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ram_addr));
  // R5: output enable only with chip selected in read mode
  p_oe_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !ram_rd_n |-> (!ram_sel_n && ram_sel && ram_wr_n));
  // R6: single-cycle valid that follows an output-enable cycle
  p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_rdvalid_src_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!ram_rd_n));
  // R7: bus left undriven in the cycle after output enable rises
  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_rd_n) |=> !drive_q);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RD_WAIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_wr_n,
  output logic          ram_rd_n,
  output logic [AW-1:0] ram_addr,
  inout  wire  [DW-1:0] ram_dq
);
  logic       accept, capture;
  seq_state_t nxt_state;

  asram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RD_WAIT(RD_WAIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .accept(accept), .nxt_state(nxt_state), .capture(capture)
  );

  asram_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .nxt_state(nxt_state), .capture(capture),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_wr_n(ram_wr_n),
    .ram_rd_n(ram_rd_n), .ram_addr(ram_addr), .ram_dq(ram_dq)
  );

  // R2: busy and an accepted request never coincide
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rd_valid, ram_sel_n, ram_sel, ram_wr_n, ram_rd_n;
  logic [7:0]  rd_data;
  logic [12:0] ram_addr;
  wire  [7:0]  ram_dq;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_sel_n(ram_sel_n),
    .ram_sel(ram_sel), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
    .ram_addr(ram_addr), .ram_dq(ram_dq)
  );

  // external RAM model (256 bytes, low address bits)
  logic [7:0] mem [256];
  logic       model_on = 1'b0;
  logic       model_oe;
  assign model_oe = !ram_sel_n && ram_sel && !ram_rd_n && ram_wr_n;
  assign ram_dq = model_oe ? mem[ram_addr[7:0]] : 8'bz;
  always @(posedge ram_wr_n)
    if (model_on && !ram_sel_n && ram_sel) mem[ram_addr[7:0]] <= ram_dq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
    chk("R2 busy after accept", busy, 1);
    chk("R3 setup sel_n", ram_sel_n, 0);
    chk("R3 setup we_n", ram_wr_n, 1);
    chk("R3 setup data", ram_dq, d);
    chk("R4 setup addr", ram_addr, a);
    @(negedge clk);
    chk("R3 pulse we_n c1", ram_wr_n, 0);
    @(negedge clk);
    chk("R3 pulse we_n c2", ram_wr_n, 0);
    chk("R4 pulse addr", ram_addr, a);
    @(negedge clk);
    chk("R3 hold we_n", ram_wr_n, 1);
    chk("R3 hold data", ram_dq, d);
    chk("R4 hold addr", ram_addr, a);
    @(negedge clk);
    chk("R3 end busy", busy, 0);
    chk("R3 end sel_n", ram_sel_n, 1);
  endtask

  task automatic do_read(input logic [12:0] a, input logic [7:0] e);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    chk("R5 setup oe_n", ram_rd_n, 1);
    chk("R5 setup sel", ram_sel, 1);
    chk("R5 setup addr", ram_addr, a);
    @(negedge clk);
    chk("R5 wait oe_n c1", ram_rd_n, 0);
    @(negedge clk);
    chk("R5 wait oe_n c2", ram_rd_n, 0);
    chk("R6 no early valid", rd_valid, 0);
    @(negedge clk);
    chk("R7 turn oe_n", ram_rd_n, 1);
    chk("R7 turn busy", busy, 1);
    chk("R6 valid", rd_valid, 1);
    chk("R9 read data", rd_data, e);
    @(negedge clk);
    chk("R6 valid drop", rd_valid, 0);
    chk("R6 data held", rd_data, e);
    chk("R7 idle busy", busy, 0);
  endtask

  // {write, addr, data}; read entries carry the expected byte
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 13'h0012, 8'hA5}, {1'b1, 13'h1F34, 8'h3C},
    {1'b1, 13'h0A56, 8'hFF}, {1'b1, 13'h0078, 8'h00},
    {1'b0, 13'h1F34, 8'h3C}, {1'b0, 13'h0012, 8'hA5},
    {1'b0, 13'h0078, 8'h00}, {1'b0, 13'h0A56, 8'hFF},
    {1'b1, 13'h0012, 8'h69}, {1'b0, 13'h0012, 8'h69}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    model_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_n", ram_sel_n, 1);
    chk("R1 sel", ram_sel, 0);
    chk("R1 we_n", ram_wr_n, 1);
    chk("R1 oe_n", ram_rd_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][21]) do_write(VEC[i][20:8], VEC[i][7:0]);
      else            do_read (VEC[i][20:8], VEC[i][7:0]);
    end

    // R2: request held during a write is ignored
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 13'h0099; req_wdata = 8'h5A;
    @(negedge clk); req_addr = 13'h00C3; req_wdata = 8'hEE;
    chk("R2 addr kept c1", ram_addr, 13'h0099);
    @(negedge clk);
    chk("R2 addr kept c2", ram_addr, 13'h0099);
    @(negedge clk);
    chk("R2 addr kept c3", ram_addr, 13'h0099);
    @(negedge clk); req_valid = 0;
    chk("R2 addr kept c4", ram_addr, 13'h0099);
    @(negedge clk);
    chk("R2 no new sequence", busy, 0);
    chk("R2 no new select", ram_sel_n, 1);
    do_read(13'h00C3, 8'h00);
    do_read(13'h0099, 8'h5A);

    // R1: reset in the middle of a read
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 13'h0012;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk("R5 oe before reset", ram_rd_n, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid reset oe_n", ram_rd_n, 1);
    chk("R1 mid reset sel_n", ram_sel_n, 1);
    chk("R1 mid reset busy", busy, 0);
    chk("R1 mid reset valid", rd_valid, 0);
    @(negedge clk);
    chk("R1 stays idle", busy, 0);
    do_read(13'h0012, 8'h69);

    finish_run();
  end
endmodule